// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor core. It accepts a parameterised number of level-sensitive request lines from on-chip peripherals, plus two active-low external pins. Each external pin can be set to capture a falling edge or to follow the pin level. Every source has an enable bit and a two-bit priority. The priority is assembled from one bit of a low priority register and the same bit of a high priority register. A global enable sits above all the per-source enables.

The controller keeps one in-service flag for each of the four priority levels, so service routines can nest. Arbitration runs only when the core signals an instruction boundary. The winning request is registered together with its vector index and level, and is held until the core acknowledges it. A return strobe retires the innermost active level. While the core sleeps, an enabled external interrupt raises a wake output.

Configuration is written through a small port. `wr_sel` picks the register:
- 0: per-source enable
- 1: priority low bit
- 2: priority high bit
- 3: control, where data bit 0 is the global enable, bit 1 selects edge mode for external pin 0, and bit 2 selects edge mode for external pin 1.

Source numbering is: index 0 is external pin 0, index 1 is external pin 1, and index 2+k is `irq_in[k]`.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset, `irq_req`, `in_service` and `wake` are 0, and all enables, priorities, capture flags and edge-mode bits are cleared.
- R2: A source can be granted only when its enable bit (register 0, bit = source index) and the global enable (register 3, bit 0) are both 1.
- R3: A source's level is {high bit, low bit}, taken from registers 2 and 1 at the source's bit position; 3 is the highest level. Among eligible requests the highest level is granted.
- R4: Among eligible requests of equal level, the lowest source index wins: pin 0, then pin 1, then `irq_in[0]` upward.
- R5: While any level is in service, only a request of strictly higher level than the highest in-service level is eligible. An acknowledge sets the in-service bit of the granted level (`in_service[n]` is level n).
- R6: While level 3 is in service, no request is issued.
- R7: Arbitration happens only in a cycle where `boundary` is 1. `irq_req`, `irq_vec` and `irq_lvl` are registered, and are held unchanged until `ack`.
- R8: In edge mode, an external pin sampled high in one cycle and low in the next sets that pin's request flag. The flag is cleared when that source is acknowledged.
- R9: In level mode, a low external pin requests directly and nothing is latched. The pin going high withdraws the request.
- R10: `wake` is 1 while `sleep` is 1 and an external source is requesting, enabled, and globally enabled; otherwise it is 0.
- R11: `reti` clears the highest set in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NSRC | Peripheral request lines, active high |
| ext_pin_n | input | 2 | External interrupt pins, active low |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Register select: 0 enable, 1 priority low, 2 priority high, 3 control |
| wr_data | input | NSRC+2 | Write data |
| boundary | input | 1 | Instruction boundary, arbitration allowed |
| ack | input | 1 | Core accepts the pending request |
| reti | input | 1 | Return from interrupt |
| sleep | input | 1 | Core is idle or powered down |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | $clog2(NSRC+2) | Index of the granted source |
| irq_lvl | output | 2 | Level of the granted source |
| in_service | output | 4 | In-service flag per level |
| wake | output | 1 | Wake request during sleep |

## Verification
The bench builds the block with NSRC=6, which gives eight sources and a three-bit vector. With that size, random enables, priorities and request patterns regularly produce ties within one level as well as every level combination. Repeated grants can also stack several levels in service, so nesting up to level 3 and the unwinding on return are reached often. Directed cases cover edge capture and its clearing on acknowledge, the level-mode release of a pin, request holding without acknowledge, and the wake output.

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl #(
  parameter int NSRC = 16,
  localparam int NTOT = NSRC + 2,
  localparam int VW = $clog2(NTOT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [1:0]      ext_pin_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [NTOT-1:0] wr_data,
  input  logic            boundary,
  input  logic            ack,
  input  logic            reti,
  input  logic            sleep,
  output logic            irq_req,
  output logic [VW-1:0]   irq_vec,
  output logic [1:0]      irq_lvl,
  output logic [3:0]      in_service,
  output logic            wake
);
  logic [NTOT-1:0] en_q, plo_q, phi_q;
  logic            gen_q;
  logic [1:0]      edge_q, samp_q, eflag_q;

  wire [1:0]      fall    = samp_q & ~ext_pin_n;
  wire [1:0]      ext_raw = (edge_q & eflag_q) | (~edge_q & ~ext_pin_n);
  wire [NTOT-1:0] pend    = {irq_in, ext_raw} & en_q & {NTOT{gen_q}};
  wire            take    = irq_req & ack;

  assign wake = sleep & gen_q & |(ext_raw & en_q[1:0]);

  logic       any_isr;
  logic [1:0] cur_lvl;
  logic [3:0] top_oh;
  always_comb begin
    any_isr = |in_service;
    cur_lvl = 2'd0;
    top_oh  = 4'd0;
    for (int l = 0; l < 4; l++)
      if (in_service[l]) begin
        cur_lvl = 2'(l);
        top_oh  = 4'd1 << l;
      end
  end

  logic          found;
  logic [1:0]    best_lvl;
  logic [VW-1:0] best_idx;
  always_comb begin
    found    = 1'b0;
    best_lvl = 2'd0;
    best_idx = '0;
    for (int i = NTOT - 1; i >= 0; i--) begin
      logic [1:0] lv;
      lv = {phi_q[i], plo_q[i]};
      if (pend[i] && (!any_isr || lv > cur_lvl) && (!found || lv >= best_lvl)) begin
        found    = 1'b1;
        best_lvl = lv;
        best_idx = VW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      plo_q  <= '0;
      phi_q  <= '0;
      gen_q  <= 1'b0;
      edge_q <= 2'b00;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: en_q  <= wr_data;
        2'd1: plo_q <= wr_data;
        2'd2: phi_q <= wr_data;
        default: begin
          gen_q  <= wr_data[0];
          edge_q <= wr_data[2:1];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= 2'b11;
      eflag_q <= 2'b00;
    end else begin
      samp_q <= ext_pin_n;
      for (int e = 0; e < 2; e++) begin
        if (edge_q[e] && fall[e]) eflag_q[e] <= 1'b1;
        else if (take && irq_vec == VW'(e)) eflag_q[e] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req    <= 1'b0;
      irq_vec    <= '0;
      irq_lvl    <= 2'd0;
      in_service <= 4'd0;
    end else begin
      in_service <= (in_service & ~(reti ? top_oh : 4'd0))
                  | (take ? (4'd1 << irq_lvl) : 4'd0);
      if (take) irq_req <= 1'b0;
      else if (!irq_req && boundary && found) begin
        irq_req <= 1'b1;
        irq_vec <= best_idx;
        irq_lvl <= best_lvl;
      end
    end
  end
endmodule

// File: rtl/nested_irq_ctrl_chk.sv
module nested_irq_ctrl_chk #(parameter int VW = 5) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          reti,
  input logic          sleep,
  input logic          gen,
  input logic          irq_req,
  input logic [VW-1:0] irq_vec,
  input logic [1:0]    irq_lvl,
  input logic [3:0]    in_service,
  input logic          wake
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !ack |=> irq_req && irq_vec == $past(irq_vec) && irq_lvl == $past(irq_lvl)); // R7
  AST_ACK_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && ack |=> in_service[$past(irq_lvl)]); // R5
  AST_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    in_service[3] && !irq_req |=> !irq_req); // R6
  AST_GLOBAL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !gen && !irq_req |=> !irq_req); // R2
  AST_RETI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    reti && !(irq_req && ack) && (in_service != 4'd0) |=>
    $countones(in_service) == $countones($past(in_service)) - 1); // R11
  AST_WAKE_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> sleep); // R10
endmodule

bind nested_irq_ctrl nested_irq_ctrl_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .reti(reti), .sleep(sleep), .gen(gen_q),
  .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
  .in_service(in_service), .wake(wake)
);

// File: tb/nested_irq_ctrl_test.sv
module nested_irq_ctrl_test;
  localparam int NSRC = 6;
  localparam int NTOT = NSRC + 2;
  localparam int VW = $clog2(NTOT);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] irq_in = '0;
  logic [1:0] ext_pin_n = 2'b11;
  logic wr_en = 0, boundary = 0, ack = 0, reti = 0, sleep = 0;
  logic [1:0] wr_sel = 0;
  logic [NTOT-1:0] wr_data = '0;
  logic irq_req, wake;
  logic [VW-1:0] irq_vec;
  logic [1:0] irq_lvl;
  logic [3:0] in_service;

  int total = 0, bad = 0;
  logic [NTOT-1:0] m_en = '0, m_lo = '0, m_hi = '0;
  logic m_gen = 0;
  logic [3:0] m_isr = '0;

  always #5 clk = ~clk;

  nested_irq_ctrl #(.NSRC(NSRC)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ext_pin_n(ext_pin_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .boundary(boundary),
    .ack(ack), .reti(reti), .sleep(sleep), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_lvl(irq_lvl), .in_service(in_service), .wake(wake)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [1:0] s, input logic [NTOT-1:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; cyc(); wr_en = 0;
    case (s)
      2'd0: m_en = d;
      2'd1: m_lo = d;
      2'd2: m_hi = d;
      default: m_gen = d[0];
    endcase
  endtask

  function automatic logic [5:0] arb(input logic [NTOT-1:0] raw);
    logic f; logic [1:0] bl, cur; logic [2:0] bi; logic any;
    f = 0; bl = 0; bi = 0; any = |m_isr; cur = 0;
    for (int l = 0; l < 4; l++) if (m_isr[l]) cur = 2'(l);
    for (int i = NTOT - 1; i >= 0; i--) begin
      logic [1:0] lv;
      lv = {m_hi[i], m_lo[i]};
      if (raw[i] && m_en[i] && m_gen && (!any || lv > cur) && (!f || lv >= bl)) begin
        f = 1; bl = lv; bi = 3'(i);
      end
    end
    return {f, bl, bi};
  endfunction

  task automatic bnd(input string tag, input logic [5:0] e);
    boundary = 1; cyc(); boundary = 0;
    chk(irq_req == e[5], tag, irq_req, e[5]);
    if (e[5]) chk({irq_lvl, irq_vec} == e[4:0], tag, {irq_lvl, irq_vec}, e[4:0]);
  endtask

  task automatic do_ack();
    m_isr[irq_lvl] = 1'b1;
    ack = 1; cyc(); ack = 0;
    chk(!irq_req && in_service == m_isr, "R5 ack", in_service, m_isr);
  endtask

  task automatic do_reti();
    for (int l = 3; l >= 0; l--) if (m_isr[l]) begin m_isr[l] = 1'b0; break; end
    reti = 1; cyc(); reti = 0;
    chk(in_service == m_isr, "R11 reti", in_service, m_isr);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5EED));
    cyc(); cyc(); rst_n = 1; cyc();
    chk(!irq_req && in_service == 0 && !wake, "R1 reset outputs", {irq_req, in_service, wake}, 0);
    irq_in = '1; ext_pin_n = 2'b00; sleep = 1;
    chk(!wake, "R1 wake cleared", wake, 0);
    bnd("R1 nothing enabled", 6'd0);
    ext_pin_n = 2'b11; sleep = 0; irq_in = '0;

    wr(0, 8'h04); irq_in = 6'b000001;
    bnd("R2 global off", 6'd0);
    wr(3, 8'h01);
    bnd("R2 grant src2", {1'b1, 2'd0, 3'd2});
    do_ack(); do_reti();

    wr(0, 8'hFF); irq_in = 6'b000110;
    bnd("R4 tie lowest index", {1'b1, 2'd0, 3'd3});
    do_ack(); do_reti();

    wr(2, 8'h80); irq_in = 6'b111111;
    bnd("R3 level 2 wins", {1'b1, 2'd2, 3'd7});
    do_ack();
    bnd("R5 equal level blocked", 6'd0);
    wr(1, 8'h20); wr(2, 8'hA0);
    bnd("R5 higher preempts", {1'b1, 2'd3, 3'd5});
    do_ack();
    wr(1, 8'h60); wr(2, 8'hE0);
    bnd("R6 level 3 not preempted", 6'd0);
    do_reti();
    chk(in_service == 4'b0100, "R11 inner level retired", in_service, 4'b0100);
    do_reti();

    wr(1, 8'h00); wr(2, 8'h00); irq_in = 6'b000001;
    repeat (3) cyc();
    chk(!irq_req, "R7 no boundary no request", irq_req, 0);
    bnd("R7 grant", {1'b1, 2'd0, 3'd2});
    irq_in = '0; wr(0, 8'h00);
    repeat (3) cyc();
    chk(irq_req && irq_vec == 2, "R7 held until ack", {irq_req, irq_vec}, {1'b1, 3'd2});
    do_ack(); do_reti();

    wr(0, 8'h03); wr(3, 8'h03);
    ext_pin_n[0] = 0; cyc(); ext_pin_n[0] = 1; cyc();
    bnd("R8 edge captured", {1'b1, 2'd0, 3'd0});
    do_ack(); do_reti();
    bnd("R8 flag cleared by ack", 6'd0);

    ext_pin_n[1] = 0; cyc();
    bnd("R9 level request", {1'b1, 2'd0, 3'd1});
    do_ack(); do_reti();
    ext_pin_n[1] = 1; cyc();
    bnd("R9 not latched", 6'd0);

    sleep = 1; ext_pin_n[1] = 0; #1;
    chk(wake, "R10 wake on pin", wake, 1);
    ext_pin_n[1] = 1; #1;
    chk(!wake, "R10 wake drops", wake, 0);
    sleep = 0; ext_pin_n[1] = 0; #1;
    chk(!wake, "R10 awake no wake", wake, 0);
    ext_pin_n[1] = 1; cyc();

    wr(3, 8'h01);
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) wr(0, 8'($urandom));
      else if (r == 1) wr(1, 8'($urandom));
      else if (r == 2) wr(2, 8'($urandom));
      else if (r == 3) wr(3, {7'd0, ($urandom_range(0, 7) != 0)});
      irq_in = 6'($urandom); ext_pin_n = 2'($urandom);
      cyc();
      bnd("R3 R4 random arbitration", arb({irq_in, ~ext_pin_n}));
      if (irq_req) do_ack();
      if (m_isr != 0 && $urandom_range(0, 2) == 0) do_reti();
    end
    while (m_isr != 0) do_reti();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule